// File: doc/BRIEF.md
# Dual-Mode Parallel Port with High-Address Takeover

This block is an 8-bit bidirectional parallel port that sits on a simple microcontroller register bus. Software sees two registers: a data latch and a per-pin direction register. While the chip runs self-contained (single-chip or bootstrap operation) the port is ordinary GPIO. Each pin is an input or an output under its direction bit. Input pins may request a pull-up when a shared pull-up select is raised.

When the chip runs with an external memory bus (expanded or test operation), the port gives its eight pins to the upper byte of the address bus. Every pin becomes an output. Pin n carries address bit n+8. Both registers then drop out of the memory map, so another responder may claim those offsets. Pin levels are brought into the clock domain through a two-flop synchronizer before software can read them.

The register bus has no back-pressure. An access completes in the cycle that `bus_sel_i` is high. Read data and the hit flag are combinational from that cycle's request. A write takes effect at the rising edge that ends the cycle.

Top module: `gpio_addr_port`

## Requirements
- R1: While `rst_n` is low, and at the first rising edge after release, every direction bit is 0. In GPIO mode that gives `pin_oe_o` = 0x00.
- R2: The data latch decodes at bus offset 0x04 and the direction register at offset 0x02. In GPIO mode (`mode_i` = 2'b00 single-chip or 2'b01 bootstrap) an access with `bus_sel_i` high to either offset raises `bus_hit_o` in the same cycle. A write (`bus_wr_i` high) loads `bus_wdata_i` at the closing rising edge. A read of the direction register returns its stored value.
- R3: In GPIO mode, `pin_oe_o[n]` equals direction bit n, and `pin_o[n]` equals data latch bit n.
- R4: In GPIO mode, a read of offset 0x04 returns the latch bit for each pin whose direction bit is 1. It returns the synchronized pin level for each pin whose direction bit is 0.
- R5: A level applied on `pin_i` shows up in a data read after the second rising edge that follows the change. Read data is unaffected by pin changes that have not yet passed both edges.
- R6: Reset leaves the data latch unchanged. A value written before reset reads back once the direction register is set to 0xFF again.
- R7: In expanded (`mode_i` = 2'b10) or test (2'b11) mode, `pin_o` equals `addr_hi_i`, `pin_oe_o` is 0xFF and `pin_pu_o` is 0x00, all in the same cycle.
- R8: In expanded or test mode, accesses to offsets 0x02 and 0x04 leave `bus_hit_o` low and `bus_rdata_o` at 0x00. Writes there change neither register, as seen by read-back after returning to GPIO mode.
- R9: An access to any other offset leaves `bus_hit_o` low and `bus_rdata_o` at 0x00, and changes neither register. With `bus_sel_i` low, `bus_rdata_o` is 0x00.
- R10: `pin_pu_o[n]` is high exactly when `pu_sel_i` is high, the port is in GPIO mode and direction bit n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode: 00 single-chip, 01 bootstrap, 10 expanded, 11 test |
| addr_hi_i | input | 8 | Internal address bits 15..8 |
| bus_sel_i | input | 1 | Register access request this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, 0 when not claimed |
| bus_hit_o | output | 1 | Access claimed by this port |
| pu_sel_i | input | 1 | Global pull-up select for input pins |
| pin_i | input | 8 | Pad input levels, asynchronous |
| pin_o | output | 8 | Pad output levels |
| pin_oe_o | output | 8 | Pad output enables |
| pin_pu_o | output | 8 | Pad pull-up enables |

## Verification
The assertions assume that `mode_i` changes only between accesses and is a known value at every sampled edge. They also assume that `bus_sel_i` and `bus_wr_i` are never unknown after reset. The stimulus drives every input at the falling edge, so these hold. Pins are left steady for at least two rising edges before any data read that depends on them. That keeps the synchronizer delay fixed and predictable for the bench model. The data latch is written before anything that exposes it, because reset leaves it unknown.

// File: rtl/port_pkg.sv
package port_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_BOOT   = 2'b01,
    MODE_EXP    = 2'b10,
    MODE_TEST   = 2'b11
  } port_mode_e;

  // Upper mode bit hands the pins to the address bus.
  function automatic logic mode_is_gpio(input port_mode_e m);
    return (m == MODE_SINGLE) || (m == MODE_BOOT);
  endfunction

endpackage

// File: rtl/port_sync.sv
module port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q[s] <= '0;
      end else if (s == 0) begin
        chain_q[s] <= async_i;
      end else begin
        chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/port_regs.sv
module port_regs #(
  parameter int                WIDTH    = 8,
  parameter int                AW       = 6,
  parameter logic [AW-1:0]     DATA_OFS = 6'h04,
  parameter logic [AW-1:0]     DIR_OFS  = 6'h02
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gpio_en,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] pin_sync_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             hit_o,
  output logic [WIDTH-1:0] dat_q,
  output logic [WIDTH-1:0] ddr_q
);

  logic hit_dat, hit_dir;
  logic [WIDTH-1:0] mixed;

  assign hit_dat = sel_i && gpio_en && (addr_i == DATA_OFS);
  assign hit_dir = sel_i && gpio_en && (addr_i == DIR_OFS);
  assign hit_o   = hit_dat || hit_dir;

  // Data latch keeps its contents through reset.
  always_ff @(posedge clk) begin
    if (hit_dat && wr_i) dat_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ddr_q <= '0;
    end else if (hit_dir && wr_i) begin
      ddr_q <= wdata_i;
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_mix
    assign mixed[b] = ddr_q[b] ? dat_q[b] : pin_sync_i[b];
  end

  always_comb begin
    rdata_o = '0;
    if (hit_dat)      rdata_o = mixed;
    else if (hit_dir) rdata_o = ddr_q;
  end

  assert_dir_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (ddr_q == '0));

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && wr_i && gpio_en && addr_i == DIR_OFS) |=> (ddr_q == $past(wdata_i)));

  assert_no_write_addr_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && wr_i && !gpio_en) |=> $stable(ddr_q));

endmodule

// File: rtl/port_pinmux.sv
module port_pinmux #(
  parameter int WIDTH = 8
) (
  input  logic             gpio_en,
  input  logic             pu_sel_i,
  input  logic [WIDTH-1:0] addr_hi_i,
  input  logic [WIDTH-1:0] dat_i,
  input  logic [WIDTH-1:0] ddr_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe_o,
  output logic [WIDTH-1:0] pin_pu_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_pin
    always_comb begin
      if (gpio_en) begin
        pin_o[b]    = dat_i[b];
        pin_oe_o[b] = ddr_i[b];
        pin_pu_o[b] = pu_sel_i && !ddr_i[b];
      end else begin
        pin_o[b]    = addr_hi_i[b];
        pin_oe_o[b] = 1'b1;
        pin_pu_o[b] = 1'b0;
      end
    end
  end

  always_comb begin
    assert_pu_never_on_output_R10: assert ((pin_pu_o & pin_oe_o) == '0);
  end

endmodule

// File: rtl/gpio_addr_port.sv
module gpio_addr_port
  import port_pkg::*;
#(
  parameter int            WIDTH    = 8,
  parameter int            AW       = 6,
  parameter logic [AW-1:0] DATA_OFS = 6'h04,
  parameter logic [AW-1:0] DIR_OFS  = 6'h02,
  parameter int            SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [WIDTH-1:0] addr_hi_i,
  input  logic             bus_sel_i,
  input  logic             bus_wr_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [WIDTH-1:0] bus_wdata_i,
  output logic [WIDTH-1:0] bus_rdata_o,
  output logic             bus_hit_o,
  input  logic             pu_sel_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe_o,
  output logic [WIDTH-1:0] pin_pu_o
);

  logic             gpio_en;
  logic [WIDTH-1:0] pin_sync, dat_q, ddr_q;

  assign gpio_en = mode_is_gpio(port_mode_e'(mode_i));

  port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  port_regs #(.WIDTH(WIDTH), .AW(AW), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .gpio_en    (gpio_en),
    .sel_i      (bus_sel_i),
    .wr_i       (bus_wr_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .pin_sync_i (pin_sync),
    .rdata_o    (bus_rdata_o),
    .hit_o      (bus_hit_o),
    .dat_q      (dat_q),
    .ddr_q      (ddr_q)
  );

  port_pinmux #(.WIDTH(WIDTH)) u_pinmux (
    .gpio_en   (gpio_en),
    .pu_sel_i  (pu_sel_i),
    .addr_hi_i (addr_hi_i),
    .dat_i     (dat_q),
    .ddr_i     (ddr_q),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o),
    .pin_pu_o  (pin_pu_o)
  );

  assert_addr_takeover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i[1] |-> (pin_oe_o == '1) && (pin_o == addr_hi_i) && (pin_pu_o == '0));

  assert_unmapped_in_addr_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i[1] |-> !bus_hit_o);

  assert_quiet_when_unclaimed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_hit_o |-> (bus_rdata_o == '0));

  assert_oe_follows_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i[1] && bus_sel_i && bus_wr_i && bus_addr_i == DIR_OFS) |=> (pin_oe_o == $past(bus_wdata_i)));

endmodule

// File: tb/test_gpio_addr_port.sv
module test_gpio_addr_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int AW = 6;
  localparam logic [AW-1:0] OFS_DAT = 6'h04;
  localparam logic [AW-1:0] OFS_DIR = 6'h02;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [W-1:0] addr_hi_i = '0, bus_wdata_i = '0, pin_i = '0;
  logic bus_sel_i = 1'b0, bus_wr_i = 1'b0, pu_sel_i = 1'b0;
  logic [AW-1:0] bus_addr_i = '0;
  logic [W-1:0] bus_rdata_o, pin_o, pin_oe_o, pin_pu_o;
  logic bus_hit_o;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [W-1:0] m_dat, m_dir;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_addr_port i_gpio_addr_port (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .addr_hi_i(addr_hi_i),
    .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .bus_hit_o(bus_hit_o),
    .pu_sel_i(pu_sel_i), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
    .pin_pu_o(pin_pu_o)
  );

  function automatic logic [W-1:0] exp_read_dat(logic [W-1:0] d, logic [W-1:0] r, logic [W-1:0] p);
    return (r & d) | (~r & p);
  endfunction

  function automatic logic [W-1:0] exp_pu(logic s, logic [1:0] m, logic [W-1:0] r);
    return (s && !m[1]) ? ~r : '0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Write at a falling edge; the closing rising edge stores it.
  task automatic bus_write(logic [AW-1:0] a, logic [W-1:0] d);
    bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_sel_i = 1'b0; bus_wr_i = 1'b0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [W-1:0] d, output logic h);
    bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a;
    #1;
    d = bus_rdata_o; h = bus_hit_o;
    bus_sel_i = 1'b0;
    #1;
  endtask

  initial begin
    int unsigned seed = 32'd2024;
    logic [W-1:0] rd, oldpin;
    logic h;
    void'($urandom(seed));
    cyc(3);
    // R1: reset state
    check("R1 dir during reset", {24'd0, pin_oe_o}, 32'h0);
    rst_n = 1'b1;
    cyc(1);
    bus_read(OFS_DIR, rd, h);
    check("R1 dir after reset", {24'd0, rd}, 32'h0);
    check("R2 dir hit", {31'd0, h}, 32'd1);
    check("R1 oe after reset", {24'd0, pin_oe_o}, 32'h0);
    bus_sel_i = 1'b0; #1;
    check("R9 idle rdata", {24'd0, bus_rdata_o}, 32'h0);

    // R2/R3: write data and direction
    bus_write(OFS_DAT, 8'hA5); m_dat = 8'hA5;
    bus_write(OFS_DIR, 8'hFF); m_dir = 8'hFF;
    bus_read(OFS_DAT, rd, h);
    check("R2 data readback", {24'd0, rd}, 32'hA5);
    check("R3 pin_o", {24'd0, pin_o}, 32'hA5);
    check("R3 pin_oe", {24'd0, pin_oe_o}, 32'hFF);

    // R5: synchronizer latency
    bus_write(OFS_DIR, 8'h00); m_dir = 8'h00;
    pin_i = 8'h00; cyc(3);
    pin_i = 8'h3C;
    @(posedge clk); #1;
    bus_read(OFS_DAT, rd, h);
    check("R5 one edge no change", {24'd0, rd}, 32'h00);
    @(posedge clk); #1;
    bus_read(OFS_DAT, rd, h);
    check("R5 two edges visible", {24'd0, rd}, 32'h3C);
    @(negedge clk);

    // R4: mix
    bus_write(OFS_DIR, 8'hF0); m_dir = 8'hF0;
    bus_read(OFS_DAT, rd, h);
    check("R4 mixed read", {24'd0, rd}, {24'd0, exp_read_dat(m_dat, m_dir, 8'h3C)});

    // R10 pull-ups
    pu_sel_i = 1'b1; #1;
    check("R10 pu", {24'd0, pin_pu_o}, {24'd0, exp_pu(1'b1, 2'b00, m_dir)});
    pu_sel_i = 1'b0; #1;
    check("R10 pu off", {24'd0, pin_pu_o}, 32'h0);

    // R9: wrong offset
    bus_write(6'h03, 8'h11);
    bus_read(6'h03, rd, h);
    check("R9 other offset hit", {31'd0, h}, 32'd0);
    check("R9 other offset rdata", {24'd0, rd}, 32'h0);
    bus_read(OFS_DIR, rd, h);
    check("R9 dir untouched", {24'd0, rd}, {24'd0, m_dir});

    // R7/R8: expanded and test
    for (int m = 2; m < 4; m++) begin
      mode_i = m[1:0]; addr_hi_i = 8'h5A ^ m[7:0]; pu_sel_i = 1'b1; #1;
      check("R7 pin_o addr", {24'd0, pin_o}, {24'd0, addr_hi_i});
      check("R7 oe all", {24'd0, pin_oe_o}, 32'hFF);
      check("R7 pu off", {24'd0, pin_pu_o}, 32'h0);
      bus_write(OFS_DIR, 8'h0F);
      bus_write(OFS_DAT, 8'h77);
      bus_read(OFS_DAT, rd, h);
      check("R8 no hit", {31'd0, h}, 32'd0);
      check("R8 rdata zero", {24'd0, rd}, 32'h0);
      pu_sel_i = 1'b0;
      mode_i = 2'b01; #1;
      bus_read(OFS_DIR, rd, h);
      check("R8 dir unchanged", {24'd0, rd}, {24'd0, m_dir});
      check("R8 data unchanged", {24'd0, pin_o & m_dir}, {24'd0, m_dat & m_dir});
    end

    // R6: data survives reset
    bus_write(OFS_DAT, 8'hC3); m_dat = 8'hC3;
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
    m_dir = 8'h00;
    bus_read(OFS_DIR, rd, h);
    check("R1 dir cleared again", {24'd0, rd}, 32'h0);
    bus_write(OFS_DIR, 8'hFF); m_dir = 8'hFF;
    bus_read(OFS_DAT, rd, h);
    check("R6 data kept", {24'd0, rd}, 32'hC3);

    // Random mix
    for (int it = 0; it < 300; it++) begin
      logic [1:0] md;
      logic [W-1:0] v;
      logic [AW-1:0] a;
      md = $urandom_range(0, 3);
      mode_i = md; addr_hi_i = $urandom; pu_sel_i = $urandom_range(0, 1);
      oldpin = $urandom; pin_i = oldpin;
      v = $urandom;
      case ($urandom_range(0, 2))
        0: a = OFS_DAT;
        1: a = OFS_DIR;
        default: a = $urandom;
      endcase
      bus_write(a, v);
      if (!md[1] && a == OFS_DAT) m_dat = v;
      if (!md[1] && a == OFS_DIR) m_dir = v;
      cyc(2);
      #1;
      if (md[1]) begin
        check("R7 rnd pins", {24'd0, pin_o}, {24'd0, addr_hi_i});
        check("R7 rnd oe", {24'd0, pin_oe_o}, 32'hFF);
      end else begin
        check("R3 rnd oe", {24'd0, pin_oe_o}, {24'd0, m_dir});
        check("R3 rnd pins", {24'd0, pin_o}, {24'd0, m_dat});
      end
      check("R10 rnd pu", {24'd0, pin_pu_o}, {24'd0, exp_pu(pu_sel_i, md, m_dir)});
      bus_read(OFS_DAT, rd, h);
      check("R4 rnd read", {23'd0, h, rd},
            md[1] ? 32'h0 : {23'd0, 1'b1, exp_read_dat(m_dat, m_dir, oldpin)});
      bus_read(OFS_DIR, rd, h);
      check("R2 rnd dir", {23'd0, h, rd}, md[1] ? 32'h0 : {23'd0, 1'b1, m_dir});
      @(negedge clk);
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule